// File: doc/BRIEF.md
# Compressed display refresh controller

This block feeds the display of a graphics system whose frame buffer sits in shared memory. Memory holds two copies of the screen. Software reads and writes the plain copy. A run-length compressed copy exists only to make refresh cheaper. The block keeps two bits per screen line. The dirty bit is set by any host write that lands in the line. The valid bit says the compressed copy of the line can be trusted.

On each refresh the block walks every line in raster order and chooses a source for that line. A line that is dirty, or has no valid compressed copy, is read pixel by pixel from the plain buffer and sent to the display. While it is sent, the block run-length encodes it and writes the encoded bytes into the line's slot in the compressed buffer. The encoded line is accepted only if its total size is within a threshold. The threshold is in bytes and is captured when the refresh starts. A clean line with a valid copy is read from its slot and expanded on the way out. In both cases the display receives the same pixels in the same order.

Memory is reached through three simple ports: a plain-buffer read port, a compressed-buffer read port and a compressed-buffer write port. The display side is a valid/ready pixel stream with a start-of-line flag.

Top module: `zline_refresh_ctrl`

## Requirements
- R1: After reset there is no display output and no memory request until refresh_start is pulsed. Every line starts dirty and without a valid copy, so the first refresh reads all LINE_PIX pixels of every line from the plain buffer and makes no compressed read.
- R2: A refresh emits LINES*LINE_PIX pixels in raster order. Each pixel equals the plain-buffer byte at line*LINE_PIX+pixel, and dout_sol is 1 exactly on pixel 0 of each line, whichever buffer supplies the line. While dout_valid is 1 and dout_ready is 0, the data and the flag hold.
- R3: A line that is dirty or lacks a valid copy is read from the plain buffer. A clean line with a valid copy is read only from its compressed slot, using one read per stored byte and no plain-buffer read.
- R4: The compressed format is a sequence of byte pairs: a count byte (1 to 255) at an even offset, then the pixel value. Runs appear in pixel order. A run longer than 255 is split. Line L's slot starts at address L*2*LINE_PIX.
- R5: While a line is recompressed, only the encoded bytes whose offset is below the threshold are written. The line becomes valid only if the total encoded size is at or below the threshold; a line that is exactly at the threshold is accepted. The threshold is captured at refresh_start.
- R6: An accepted write-back clears the line's dirty bit and sets its valid bit, so the next refresh takes the line from the compressed buffer. A rejected line is recompressed again on every refresh.
- R7: A host write naming a line sets its dirty bit. The next refresh then takes that line from the plain buffer and recompresses it from the new contents.
- R8: A host write to a line while that same line is being recompressed cancels its acceptance. The line stays dirty and is read from the plain buffer on the following refresh.
- R9: A refresh_start pulse during a refresh in progress is ignored. No extra pixels are emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_start | input | 1 | Pulse that starts one screen refresh |
| thresh | input | BW | Size limit in bytes for an accepted compressed line |
| host_wr_valid | input | 1 | A host write touched a line |
| host_wr_line | input | LW | Line index of that host write |
| ureq_valid | output | 1 | Plain-buffer read request |
| ureq_addr | output | UAW | Plain-buffer byte address |
| ureq_ready | input | 1 | Plain-buffer request accepted |
| ursp_valid | input | 1 | Plain-buffer read data valid |
| ursp_data | input | PIX_W | Plain-buffer read data |
| creq_valid | output | 1 | Compressed-buffer read request |
| creq_addr | output | CAW | Compressed-buffer byte address |
| creq_ready | input | 1 | Compressed-buffer request accepted |
| crsp_valid | input | 1 | Compressed-buffer read data valid |
| crsp_data | input | PIX_W | Compressed-buffer read data |
| cw_valid | output | 1 | Compressed-buffer write |
| cw_addr | output | CAW | Compressed-buffer write address |
| cw_data | output | PIX_W | Compressed-buffer write byte |
| cw_ready | input | 1 | Write accepted |
| dout_valid | output | 1 | Display pixel valid |
| dout_data | output | PIX_W | Display pixel |
| dout_sol | output | 1 | First pixel of a line |
| dout_ready | input | 1 | Display accepts the pixel |

## Verification
The assertions check four properties on every cycle. The display pixel and its flag hold while the display stalls. No compressed write lands at or beyond the threshold offset of the current line. Every count byte written is nonzero. The tag bits follow host writes and accepted write-backs, and an accepted write-back never coincides with a host write to the same line. Only the bench scenarios can show the frame-level effects. These are the choice of source per line across successive refreshes, the exact encoded bytes including a run split at 255, and acceptance right at the threshold against rejection just above it. They also cover the cancel caused by a write landing mid-line and the pixel order staying the same under backpressure whichever buffer supplies a line.

// File: rtl/zr_pkg.sv
package zr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LINE, ST_UREQ, ST_UWAIT, ST_UOUT, ST_ENC,
    ST_WR0, ST_WR1, ST_COMMIT, ST_CREQ, ST_CWAIT, ST_COUT, ST_NEXT
  } zr_state_e;
endpackage

// File: rtl/zr_line_tags.sv
module zr_line_tags #(
  parameter int LINES = 768,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [LW-1:0] host_line,
  input  logic [LW-1:0] cur_line,
  input  logic          invalidate,
  input  logic          commit,
  output logic          cur_dirty,
  output logic          cur_cvalid
);
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [LINES-1:0] cvalid_q, cvalid_d;

  always_comb begin
    dirty_d  = dirty_q;
    cvalid_d = cvalid_q;
    if (invalidate) cvalid_d[cur_line] = 1'b0;
    if (commit) begin
      cvalid_d[cur_line] = 1'b1;
      dirty_d[cur_line]  = 1'b0;
    end
    if (host_wr) dirty_d[host_line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q  <= '1;
      cvalid_q <= '0;
    end else begin
      dirty_q  <= dirty_d;
      cvalid_q <= cvalid_d;
    end
  end

  assign cur_dirty  = dirty_q[cur_line];
  assign cur_cvalid = cvalid_q[cur_line];

  // R7
  host_sets_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> dirty_q[$past(host_line)]);

  // R6
  commit_marks_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cvalid_q[$past(cur_line)] && !dirty_q[$past(cur_line)]));

  // R8
  commit_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !(host_wr && host_line == cur_line));
endmodule

// File: rtl/zr_rle_run.sv
module zr_rle_run #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] run_cnt,
  output logic [PIX_W-1:0] run_pix,
  output logic             brk
);
  localparam logic [PIX_W-1:0] RUN_MAX = '1;

  logic [PIX_W-1:0] cnt_q, cnt_d, pix_q, pix_d;

  assign brk = (cnt_q != '0) && ((pix != pix_q) || (cnt_q == RUN_MAX));

  always_comb begin
    cnt_d = cnt_q;
    pix_d = pix_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      if ((cnt_q == '0) || brk) begin
        cnt_d = PIX_W'(1);
        pix_d = pix;
      end else begin
        cnt_d = cnt_q + PIX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pix_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pix_q <= pix_d;
    end
  end

  assign run_cnt = cnt_q;
  assign run_pix = pix_q;

  // R4
  run_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (run_cnt != '0));
endmodule

// File: rtl/zline_refresh_ctrl.sv
module zline_refresh_ctrl
  import zr_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_PIX = 1024,
  parameter int LINES    = 768,
  localparam int LW   = $clog2(LINES),
  localparam int PXW  = $clog2(LINE_PIX),
  localparam int CREG = 2 * LINE_PIX,
  localparam int BW   = $clog2(CREG + 1),
  localparam int UAW  = $clog2(LINES * LINE_PIX),
  localparam int CAW  = $clog2(LINES * CREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_start,
  input  logic [BW-1:0]    thresh,
  input  logic             host_wr_valid,
  input  logic [LW-1:0]    host_wr_line,
  output logic             ureq_valid,
  output logic [UAW-1:0]   ureq_addr,
  input  logic             ureq_ready,
  input  logic             ursp_valid,
  input  logic [PIX_W-1:0] ursp_data,
  output logic             creq_valid,
  output logic [CAW-1:0]   creq_addr,
  input  logic             creq_ready,
  input  logic             crsp_valid,
  input  logic [PIX_W-1:0] crsp_data,
  output logic             cw_valid,
  output logic [CAW-1:0]   cw_addr,
  output logic [PIX_W-1:0] cw_data,
  input  logic             cw_ready,
  output logic             dout_valid,
  output logic [PIX_W-1:0] dout_data,
  output logic             dout_sol,
  input  logic             dout_ready
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  zr_state_e        state_q, state_d;
  logic [LW-1:0]    line_q, line_d;
  logic [PXW-1:0]   pix_q, pix_d;
  logic [BW-1:0]    byte_q, byte_d;
  logic [BW-1:0]    thr_q, thr_d;
  logic [PIX_W-1:0] data_q, data_d;
  logic [PIX_W-1:0] rep_q, rep_d;
  logic             cancel_q, cancel_d;
  logic             flush_q, flush_d;
  logic             sol_q, sol_d;

  logic             invalidate, commit, rle_clr, rle_load;
  logic             cur_dirty, cur_cvalid;
  logic [PIX_W-1:0] run_cnt, run_pix;
  logic             brk;
  logic             host_hit, wr_en, last_pix;
  logic [CAW-1:0]   cbase, cw_off;

  zr_line_tags #(.LINES(LINES)) u_tags (
    .clk(clk), .rst_n(rst_ns),
    .host_wr(host_wr_valid), .host_line(host_wr_line),
    .cur_line(line_q), .invalidate(invalidate), .commit(commit),
    .cur_dirty(cur_dirty), .cur_cvalid(cur_cvalid)
  );

  zr_rle_run #(.PIX_W(PIX_W)) u_run (
    .clk(clk), .rst_n(rst_ns), .clr(rle_clr), .load(rle_load),
    .pix(data_q), .run_cnt(run_cnt), .run_pix(run_pix), .brk(brk)
  );

  assign host_hit  = host_wr_valid && (host_wr_line == line_q);
  assign wr_en     = (byte_q < thr_q);
  assign last_pix  = (pix_q == PXW'(LINE_PIX - 1));
  assign cbase     = CAW'(line_q) * CAW'(CREG);
  assign ureq_addr = UAW'(line_q) * UAW'(LINE_PIX) + UAW'(pix_q);
  assign creq_addr = cbase + CAW'(byte_q);
  assign cw_addr   = cbase + CAW'(byte_q);
  assign cw_off    = cw_addr - cbase;
  assign dout_data = data_q;
  assign dout_sol  = sol_q;

  always_comb begin
    state_d    = state_q;
    line_d     = line_q;
    pix_d      = pix_q;
    byte_d     = byte_q;
    thr_d      = thr_q;
    data_d     = data_q;
    rep_d      = rep_q;
    cancel_d   = cancel_q | host_hit;
    flush_d    = flush_q;
    sol_d      = sol_q;
    invalidate = 1'b0;
    commit     = 1'b0;
    rle_clr    = 1'b0;
    rle_load   = 1'b0;
    ureq_valid = 1'b0;
    creq_valid = 1'b0;
    cw_valid   = 1'b0;
    cw_data    = run_cnt;
    dout_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (refresh_start) begin
          line_d  = '0;
          thr_d   = thresh;
          state_d = ST_LINE;
        end
      end
      ST_LINE: begin
        pix_d    = '0;
        byte_d   = '0;
        cancel_d = 1'b0;
        flush_d  = 1'b0;
        sol_d    = 1'b1;
        if (cur_dirty || !cur_cvalid) begin
          invalidate = 1'b1;
          rle_clr    = 1'b1;
          state_d    = ST_UREQ;
        end else begin
          state_d = ST_CREQ;
        end
      end
      ST_UREQ: begin
        ureq_valid = 1'b1;
        if (ureq_ready) state_d = ST_UWAIT;
      end
      ST_UWAIT: begin
        if (ursp_valid) begin
          data_d  = ursp_data;
          state_d = ST_UOUT;
        end
      end
      ST_UOUT: begin
        dout_valid = 1'b1;
        if (dout_ready) begin
          sol_d   = 1'b0;
          state_d = ST_ENC;
        end
      end
      ST_ENC: begin
        if (brk) begin
          state_d = ST_WR0;
        end else begin
          rle_load = 1'b1;
          if (last_pix) begin
            flush_d = 1'b1;
            state_d = ST_WR0;
          end else begin
            pix_d   = pix_q + PXW'(1);
            state_d = ST_UREQ;
          end
        end
      end
      ST_WR0: begin
        cw_valid = wr_en;
        cw_data  = run_cnt;
        if (!wr_en || cw_ready) begin
          byte_d  = byte_q + BW'(1);
          state_d = ST_WR1;
        end
      end
      ST_WR1: begin
        cw_valid = wr_en;
        cw_data  = run_pix;
        if (!wr_en || cw_ready) begin
          byte_d = byte_q + BW'(1);
          if (flush_q) begin
            state_d = ST_COMMIT;
          end else begin
            rle_load = 1'b1;
            if (last_pix) begin
              flush_d = 1'b1;
              state_d = ST_WR0;
            end else begin
              pix_d   = pix_q + PXW'(1);
              state_d = ST_UREQ;
            end
          end
        end
      end
      ST_COMMIT: begin
        commit  = !cancel_q && !host_hit && (byte_q <= thr_q);
        state_d = ST_NEXT;
      end
      ST_CREQ: begin
        creq_valid = 1'b1;
        if (creq_ready) state_d = ST_CWAIT;
      end
      ST_CWAIT: begin
        if (crsp_valid) begin
          byte_d = byte_q + BW'(1);
          if (!byte_q[0]) begin
            rep_d   = crsp_data;
            state_d = ST_CREQ;
          end else begin
            data_d  = crsp_data;
            state_d = ST_COUT;
          end
        end
      end
      ST_COUT: begin
        dout_valid = 1'b1;
        if (dout_ready) begin
          sol_d = 1'b0;
          rep_d = rep_q - PIX_W'(1);
          if (last_pix) begin
            state_d = ST_NEXT;
          end else begin
            pix_d = pix_q + PXW'(1);
            if (rep_q == PIX_W'(1)) state_d = ST_CREQ;
          end
        end
      end
      ST_NEXT: begin
        if (line_q == LW'(LINES - 1)) begin
          state_d = ST_IDLE;
        end else begin
          line_d  = line_q + LW'(1);
          state_d = ST_LINE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= ST_IDLE;
      line_q   <= '0;
      pix_q    <= '0;
      byte_q   <= '0;
      thr_q    <= '0;
      data_q   <= '0;
      rep_q    <= '0;
      cancel_q <= 1'b0;
      flush_q  <= 1'b0;
      sol_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      line_q   <= line_d;
      pix_q    <= pix_d;
      byte_q   <= byte_d;
      thr_q    <= thr_d;
      data_q   <= data_d;
      rep_q    <= rep_d;
      cancel_q <= cancel_d;
      flush_q  <= flush_d;
      sol_q    <= sol_d;
    end
  end

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data) && $stable(dout_sol)));

  // R5
  wr_below_thresh_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cw_valid |-> (cw_off < CAW'(thr_q)));

  // R4
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cw_valid && !cw_addr[0]) |-> (cw_data != '0));
endmodule

// File: tb/zline_refresh_ctrl_bench.sv
module zline_refresh_ctrl_bench;
  localparam int PIX_W = 8;
  localparam int LINE_PIX = 300;
  localparam int LINES = 4;
  localparam int CREG = 2 * LINE_PIX;
  localparam int LW = $clog2(LINES);
  localparam int BW = $clog2(CREG + 1);
  localparam int UAW = $clog2(LINES * LINE_PIX);
  localparam int CAW = $clog2(LINES * CREG);
  localparam int TOTAL = LINES * LINE_PIX;

  logic clk = 1'b0;
  logic rst_n;
  logic refresh_start, host_wr_valid;
  logic [LW-1:0] host_wr_line;
  logic [BW-1:0] thresh;
  logic ureq_valid, creq_valid, cw_valid, dout_valid, dout_sol;
  logic [UAW-1:0] ureq_addr;
  logic [CAW-1:0] creq_addr, cw_addr;
  logic [PIX_W-1:0] cw_data, dout_data, ursp_data, crsp_data;
  logic ursp_valid, crsp_valid, dout_ready;
  logic ureq_ready = 1'b1, creq_ready = 1'b1, cw_ready = 1'b1;

  always #5 clk = ~clk;

  zline_refresh_ctrl #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .LINES(LINES)) u_zline_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .refresh_start(refresh_start), .thresh(thresh),
    .host_wr_valid(host_wr_valid), .host_wr_line(host_wr_line),
    .ureq_valid(ureq_valid), .ureq_addr(ureq_addr), .ureq_ready(ureq_ready),
    .ursp_valid(ursp_valid), .ursp_data(ursp_data),
    .creq_valid(creq_valid), .creq_addr(creq_addr), .creq_ready(creq_ready),
    .crsp_valid(crsp_valid), .crsp_data(crsp_data),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_ready(cw_ready),
    .dout_valid(dout_valid), .dout_data(dout_data), .dout_sol(dout_sol), .dout_ready(dout_ready)
  );

  logic [PIX_W-1:0] umem [TOTAL];
  logic [PIX_W-1:0] cmem [LINES*CREG];
  int ureq_cnt [LINES];
  int creq_cnt [LINES];
  int cw_cnt [LINES];
  int out_cnt, mism, solerr;
  int n_tests = 0, n_fail = 0;
  bit bp_mode = 1'b0;
  int tick = 0;
  bit done = 1'b0;

  // memory models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ursp_valid <= 1'b0; crsp_valid <= 1'b0;
      ursp_data <= '0; crsp_data <= '0;
    end else begin
      ursp_valid <= ureq_valid && ureq_ready;
      ursp_data  <= umem[ureq_addr];
      crsp_valid <= creq_valid && creq_ready;
      crsp_data  <= cmem[creq_addr];
    end
  end

  // port monitors
  always @(posedge clk) begin
    if (rst_n) begin
      if (ureq_valid && ureq_ready) ureq_cnt[int'(ureq_addr) / LINE_PIX] += 1;
      if (creq_valid && creq_ready) creq_cnt[int'(creq_addr) / CREG] += 1;
      if (cw_valid && cw_ready) begin
        cmem[cw_addr] = cw_data;
        cw_cnt[int'(cw_addr) / CREG] += 1;
      end
      if (dout_valid && dout_ready) begin
        if (out_cnt < TOTAL) begin
          if (dout_data != umem[out_cnt]) mism += 1;
          if (dout_sol != ((out_cnt % LINE_PIX) == 0)) solerr += 1;
        end
        out_cnt += 1;
      end
    end
  end

  always @(negedge clk) begin
    tick += 1;
    dout_ready = bp_mode ? ((tick % 3) != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests += 1;
    if (!ok) begin
      n_fail += 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] img(input int l, input int p, input bit alt0);
    case (l)
      0: img = alt0 ? ((p < 150) ? 8'hA0 : 8'hA1) : 8'h11;
      1: img = 8'h20 + 8'(p / 60);
      2: img = 8'h40 + 8'(p / 100);
      default: img = 8'h60 + 8'(p / 75);
    endcase
  endfunction

  task automatic host_touch(input int l);
    @(negedge clk);
    host_wr_valid = 1'b1;
    host_wr_line = LW'(l);
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic run_frame(input bit restart_mid);
    @(negedge clk);
    for (int l = 0; l < LINES; l++) begin
      ureq_cnt[l] = 0; creq_cnt[l] = 0; cw_cnt[l] = 0;
    end
    out_cnt = 0; mism = 0; solerr = 0;
    refresh_start = 1'b1;
    @(negedge clk);
    refresh_start = 1'b0;
    for (int k = 0; out_cnt < TOTAL; k++) begin
      @(negedge clk);
      refresh_start = restart_mid && (k == 500);
    end
    refresh_start = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_pixels(input string req);
    chk(out_cnt == TOTAL, req, "pixel count", out_cnt, TOTAL);
    chk(mism == 0, req, "pixel mismatches", mism, 0);
    chk(solerr == 0, req, "start-of-line errors", solerr, 0);
  endtask

  task automatic t_reset();
    repeat (10) @(negedge clk);
    chk(!dout_valid && !ureq_valid && !creq_valid && !cw_valid, "R1", "idle after reset",
        int'({dout_valid, ureq_valid, creq_valid, cw_valid}), 0);
  endtask

  task automatic t_first_frame();
    logic [PIX_W-1:0] e3 [8];
    e3 = '{8'd75, 8'h60, 8'd75, 8'h61, 8'd75, 8'h62, 8'd75, 8'h63};
    run_frame(1'b0);
    chk_pixels("R2");
    for (int l = 0; l < LINES; l++) begin
      chk(ureq_cnt[l] == LINE_PIX, "R1", $sformatf("plain reads line %0d", l), ureq_cnt[l], LINE_PIX);
      chk(creq_cnt[l] == 0, "R1", $sformatf("compressed reads line %0d", l), creq_cnt[l], 0);
    end
    chk(cw_cnt[0] == 4, "R5", "writes line0", cw_cnt[0], 4);
    chk(cw_cnt[1] == 8, "R5", "writes line1 clipped at threshold", cw_cnt[1], 8);
    chk(cw_cnt[2] == 6, "R5", "writes line2", cw_cnt[2], 6);
    chk(cw_cnt[3] == 8, "R5", "writes line3", cw_cnt[3], 8);
    chk(cmem[0] == 8'd255, "R4", "line0 first count split at 255", int'(cmem[0]), 255);
    chk(cmem[1] == 8'h11, "R4", "line0 first pixel", int'(cmem[1]), 'h11);
    chk(cmem[2] == 8'd45, "R4", "line0 second count", int'(cmem[2]), 45);
    chk(cmem[3] == 8'h11, "R4", "line0 second pixel", int'(cmem[3]), 'h11);
    for (int i = 0; i < 8; i++)
      chk(cmem[3*CREG + i] == e3[i], "R4", $sformatf("line3 byte %0d", i),
          int'(cmem[3*CREG + i]), int'(e3[i]));
  endtask

  task automatic t_compressed_frame();
    bp_mode = 1'b1;
    run_frame(1'b0);
    bp_mode = 1'b0;
    chk_pixels("R2");
    chk(ureq_cnt[0] == 0 && creq_cnt[0] == 4, "R3", "line0 from compressed", creq_cnt[0], 4);
    chk(ureq_cnt[2] == 0 && creq_cnt[2] == 6, "R6", "line2 from compressed", creq_cnt[2], 6);
    chk(ureq_cnt[3] == 0 && creq_cnt[3] == 8, "R5", "line3 at threshold accepted", creq_cnt[3], 8);
    chk(ureq_cnt[1] == LINE_PIX && creq_cnt[1] == 0, "R5", "line1 above threshold rejected",
        ureq_cnt[1], LINE_PIX);
    chk(cw_cnt[1] == 8, "R6", "rejected line recompressed", cw_cnt[1], 8);
    chk(cw_cnt[0] + cw_cnt[2] + cw_cnt[3] == 0, "R6", "no writes for clean lines",
        cw_cnt[0] + cw_cnt[2] + cw_cnt[3], 0);
  endtask

  task automatic t_host_write();
    @(negedge clk);
    for (int p = 0; p < LINE_PIX; p++) umem[p] = img(0, p, 1'b1);
    host_touch(0);
    run_frame(1'b0);
    chk_pixels("R7");
    chk(ureq_cnt[0] == LINE_PIX && creq_cnt[0] == 0, "R7", "written line from plain buffer",
        ureq_cnt[0], LINE_PIX);
    chk(cmem[0] == 8'd150 && cmem[1] == 8'hA0 && cmem[2] == 8'd150 && cmem[3] == 8'hA1,
        "R7", "recompressed bytes", int'({cmem[0], cmem[1]}), int'({8'd150, 8'hA0}));
    run_frame(1'b0);
    chk_pixels("R7");
    chk(ureq_cnt[0] == 0 && creq_cnt[0] == 4, "R7", "rewritten line compressed again",
        creq_cnt[0], 4);
  endtask

  task automatic t_cancel();
    host_touch(2);
    fork
      run_frame(1'b0);
      begin
        do @(negedge clk); while (!(ureq_valid && ureq_addr == UAW'(2*LINE_PIX + 50)));
        host_wr_valid = 1'b1;
        host_wr_line = LW'(2);
        @(negedge clk);
        host_wr_valid = 1'b0;
      end
    join
    chk_pixels("R8");
    chk(ureq_cnt[2] == LINE_PIX, "R8", "line2 recompressed", ureq_cnt[2], LINE_PIX);
    run_frame(1'b0);
    chk(ureq_cnt[2] == LINE_PIX && creq_cnt[2] == 0, "R8", "cancelled line still plain",
        ureq_cnt[2], LINE_PIX);
    run_frame(1'b0);
    chk(ureq_cnt[2] == 0 && creq_cnt[2] == 6, "R8", "line2 compressed after clean pass",
        creq_cnt[2], 6);
  endtask

  task automatic t_restart_ignored();
    run_frame(1'b1);
    chk(out_cnt == TOTAL, "R9", "restart mid-frame ignored", out_cnt, TOTAL);
    chk(mism == 0, "R9", "pixels after ignored restart", mism, 0);
    chk(!dout_valid && !ureq_valid && !creq_valid, "R9", "idle after frame",
        int'({dout_valid, ureq_valid, creq_valid}), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    refresh_start = 1'b0;
    host_wr_valid = 1'b0;
    host_wr_line = '0;
    thresh = BW'(8);
    for (int l = 0; l < LINES; l++) begin
      ureq_cnt[l] = 0; creq_cnt[l] = 0; cw_cnt[l] = 0;
      for (int p = 0; p < LINE_PIX; p++) umem[l*LINE_PIX + p] = img(l, p, 1'b0);
    end
    for (int i = 0; i < LINES*CREG; i++) cmem[i] = '0;
    out_cnt = 0; mism = 0; solerr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_frame();
    t_compressed_frame();
    t_host_write();
    t_cancel();
    t_restart_ignored();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests += 1;
      n_fail += 1;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule